// File: doc/BRIEF.md
# Line-Fill Cacheability Decision Unit

This block decides, once per bus cycle, whether the data returned for a memory access may be allocated into a cache line. Three sources feed the decision. The first is the cache-disable attribute of the page that maps the access. The second is a small bank of programmable address-range registers, which can mark regions as uncacheable or write-combining. The third is an active-low cache-enable pin driven by system logic. Any access that none of these sources marks as uncacheable is cacheable.

A bus cycle opens with `acc_start`, which presents the address and the page attribute. The page and range classification is registered at that edge. The cache-enable pin is sampled at the first burst-ready or next-address strobe that follows. On the cycle after that strobe, the block pulses `decide_vld` and presents `fill_ok` and `mem_type`. Both outputs hold until the next decision. Range registers are loaded one at a time through a write port that sets base, mask and type together.

Top module: `linefill_cache_gate`

## Requirements
- R1: After reset, `decide_vld`, `fill_ok` and `mem_type` are all 0, and every range register has type off, so no range matches.
- R2: When no range matches, the page bit `acc_pcd` is 0 and the pin `cache_en_n` is sampled low, the decision gives `fill_ok`=1 and `mem_type`=0 (cacheable).
- R3: When `acc_pcd` is 1 and no range matches, the decision gives `mem_type`=1 (uncacheable) and `fill_ok`=0.
- R4: A range matches when `(acc_addr & mask) == (base & mask)` and its type is not off. Type codes are 0 off, 1 uncacheable, 2 write-combining. A matching type-1 range gives `mem_type`=1 and `fill_ok`=0.
- R5: A matching type-2 range, with no type-1 match, gives `mem_type`=2 and `fill_ok`=0. This holds whatever the value of `acc_pcd`.
- R6: When type-1 and type-2 ranges both match, `mem_type`=1 (the most restrictive type wins).
- R7: Type code 3 is reserved and behaves as off.
- R8: The pin is sampled at the first `burst_rdy` or `next_addr` strobe after the start cycle. `fill_ok` is 1 only if the type is cacheable and the sampled pin is low. `decide_vld` pulses for exactly one cycle, on the cycle after that strobe.
- R9: After the decision, further strobes and pin changes within the same bus cycle are ignored: no second `decide_vld`, and `fill_ok` and `mem_type` stay unchanged.
- R10: The classification is captured at `acc_start`. A range-register write made during an open bus cycle does not alter that cycle's decision, but it does apply to later accesses.
- R11: A strobe with no open bus cycle is ignored. So is a strobe in the same cycle as `acc_start`; the pin is sampled at a later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Range-register write enable |
| cfg_idx | input | IDX_W | Range register selected for writing |
| cfg_base | input | ADDR_W | Base address to write |
| cfg_mask | input | ADDR_W | Compare mask to write |
| cfg_type | input | 2 | Region type to write (0 off, 1 uncacheable, 2 write-combining, 3 reserved) |
| acc_start | input | 1 | Opens a bus cycle; address and page bit are valid |
| acc_addr | input | ADDR_W | Access address |
| acc_pcd | input | 1 | Page-level cache-disable attribute |
| burst_rdy | input | 1 | Burst-ready strobe |
| next_addr | input | 1 | Next-address strobe |
| cache_en_n | input | 1 | Active-low cache-enable pin from system logic |
| decide_vld | output | 1 | One-cycle pulse when a new decision is presented |
| fill_ok | output | 1 | Line fill permitted |
| mem_type | output | 2 | 0 cacheable, 1 uncacheable, 2 write-combining |

## Verification
The assertions assume that every input has a known value at each clock edge once reset is released. They also assume that the address and page bit are meaningful only on the `acc_start` cycle, while strobes and the pin may move freely at any time. The bench drives all inputs at falling edges, starting from defined values at time zero. It sweeps every address of an 8-bit configuration under several range setups, and adds stray strobes, same-cycle start-and-strobe and mid-cycle register writes, so that the ignore rules are exercised at the ports.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

    typedef enum logic [1:0] {
        RT_OFF = 2'd0,
        RT_UC  = 2'd1,
        RT_WC  = 2'd2,
        RT_RSV = 2'd3
    } range_type_e;

    typedef enum logic [1:0] {
        MK_WB = 2'd0,
        MK_UC = 2'd1,
        MK_WC = 2'd2
    } mem_kind_e;

    typedef struct packed {
        logic uc_hit;
        logic wc_hit;
    } range_vote_t;

    typedef enum logic {
        SP_IDLE = 1'b0,
        SP_WAIT = 1'b1
    } samp_state_e;

    // Merge rule: uncacheable range beats write-combining, which beats the page bit.
    function automatic mem_kind_e merge_kind(input range_vote_t v, input logic pcd);
        if (v.uc_hit)      return MK_UC;
        else if (v.wc_hit) return MK_WC;
        else if (pcd)      return MK_UC;
        else               return MK_WB;
    endfunction

    function automatic logic type_active(input range_type_e t);
        return (t == RT_UC) || (t == RT_WC);
    endfunction

endpackage

// File: rtl/lfc_range_entry.sv
module lfc_range_entry
    import lfc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_mask,
    input  range_type_e       wr_type,
    input  logic [ADDR_W-1:0] look_addr,
    output range_vote_t       vote
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] mask_q;
    range_type_e       type_q;
    logic              addr_eq;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            mask_q <= '0;
            type_q <= RT_OFF;
        end else if (wr_en) begin
            base_q <= wr_base;
            mask_q <= wr_mask;
            type_q <= wr_type;
        end
    end

    always_comb begin
        addr_eq     = ((look_addr & mask_q) == (base_q & mask_q));
        vote.uc_hit = addr_eq && type_active(type_q) && (type_q == RT_UC);
        vote.wc_hit = addr_eq && type_active(type_q) && (type_q == RT_WC);
    end

    // R7
    one_vote_chk: assert property (@(posedge clk) disable iff (rst)
        !(vote.uc_hit && vote.wc_hit));

endmodule

// File: rtl/lfc_range_bank.sv
module lfc_range_bank
    import lfc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_RANGES = 2,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [1:0]        cfg_type,
    input  logic [ADDR_W-1:0] look_addr,
    output range_vote_t       vote_any
);
    range_vote_t votes [NUM_RANGES];
    range_type_e wr_type;

    assign wr_type = range_type_e'(cfg_type);

    for (genvar gi = 0; gi < NUM_RANGES; gi++) begin : g_entry
        logic sel_we;
        assign sel_we = cfg_we && (cfg_idx == IDX_W'(gi));
        lfc_range_entry #(.ADDR_W(ADDR_W)) u_entry (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (sel_we),
            .wr_base  (cfg_base),
            .wr_mask  (cfg_mask),
            .wr_type  (wr_type),
            .look_addr(look_addr),
            .vote     (votes[gi])
        );
    end

    always_comb begin
        vote_any = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            vote_any.uc_hit = vote_any.uc_hit | votes[i].uc_hit;
            vote_any.wc_hit = vote_any.wc_hit | votes[i].wc_hit;
        end
    end

endmodule

// File: rtl/lfc_classify.sv
module lfc_classify
    import lfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  range_vote_t vote,
    input  logic        pcd,
    output mem_kind_e   kind
);
    assign kind = merge_kind(vote, pcd);

    // R6
    uc_wins_chk: assert property (@(posedge clk) disable iff (rst)
        vote.uc_hit |-> (kind == MK_UC));

    // R5
    wc_only_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == MK_WC) |-> (vote.wc_hit && !vote.uc_hit));

    // R3
    pcd_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        pcd |-> (kind != MK_WB));

endmodule

// File: rtl/lfc_pin_sampler.sv
module lfc_pin_sampler
    import lfc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  mem_kind_e kind_in,
    input  logic      strobe,
    input  logic      pin_n,
    output logic      vld,
    output logic      fill,
    output mem_kind_e kind_out
);
    samp_state_e st_q;
    mem_kind_e   kind_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SP_IDLE;
            kind_q   <= MK_WB;
            vld      <= 1'b0;
            fill     <= 1'b0;
            kind_out <= MK_WB;
        end else begin
            vld <= 1'b0;
            if (start) begin
                st_q   <= SP_WAIT;
                kind_q <= kind_in;
            end else if ((st_q == SP_WAIT) && strobe) begin
                st_q     <= SP_IDLE;
                vld      <= 1'b1;
                fill     <= (kind_q == MK_WB) && !pin_n;
                kind_out <= kind_q;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!vld && !fill && (kind_out == MK_WB)));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vld |=> !vld);

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |-> ($stable(fill) && $stable(kind_out)));

    // R8
    fill_needs_wb_chk: assert property (@(posedge clk) disable iff (rst)
        fill |-> (kind_out == MK_WB));

    // R11
    vld_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> $past(strobe && !start));

endmodule

// File: rtl/linefill_cache_gate.sv
module linefill_cache_gate
    import lfc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_RANGES = 2,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [1:0]        cfg_type,
    input  logic              acc_start,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_pcd,
    input  logic              burst_rdy,
    input  logic              next_addr,
    input  logic              cache_en_n,
    output logic              decide_vld,
    output logic              fill_ok,
    output logic [1:0]        mem_type
);
    range_vote_t vote;
    mem_kind_e   kind_now;
    mem_kind_e   kind_dec;
    logic        strobe;

    assign strobe   = burst_rdy | next_addr;
    assign mem_type = kind_dec;

    lfc_range_bank #(.ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_idx  (cfg_idx),
        .cfg_base (cfg_base),
        .cfg_mask (cfg_mask),
        .cfg_type (cfg_type),
        .look_addr(acc_addr),
        .vote_any (vote)
    );

    lfc_classify u_cls (
        .clk (clk),
        .rst (rst),
        .vote(vote),
        .pcd (acc_pcd),
        .kind(kind_now)
    );

    lfc_pin_sampler u_samp (
        .clk     (clk),
        .rst     (rst),
        .start   (acc_start),
        .kind_in (kind_now),
        .strobe  (strobe),
        .pin_n   (cache_en_n),
        .vld     (decide_vld),
        .fill    (fill_ok),
        .kind_out(kind_dec)
    );

    // R8
    pin_veto_chk: assert property (@(posedge clk) disable iff (rst)
        (decide_vld && fill_ok) |-> $past(!cache_en_n));

endmodule

// File: tb/linefill_cache_gate_tb.sv
`timescale 1ns/1ps
module linefill_cache_gate_tb;
    localparam int AW = 8;
    localparam int NR = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [0:0]    cfg_idx = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_mask = '0;
    logic [1:0]    cfg_type = '0;
    logic          acc_start = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_pcd = 1'b0;
    logic          burst_rdy = 1'b0;
    logic          next_addr = 1'b0;
    logic          cache_en_n = 1'b0;
    logic          decide_vld;
    logic          fill_ok;
    logic [1:0]    mem_type;

    int n_cmp = 0;
    int n_bad = 0;
    logic [AW-1:0] m_base [NR];
    logic [AW-1:0] m_mask [NR];
    logic [1:0]    m_type [NR];

    always #2.5 clk = ~clk;

    linefill_cache_gate #(.ADDR_W(AW), .NUM_RANGES(NR)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_type(cfg_type),
        .acc_start(acc_start), .acc_addr(acc_addr), .acc_pcd(acc_pcd),
        .burst_rdy(burst_rdy), .next_addr(next_addr), .cache_en_n(cache_en_n),
        .decide_vld(decide_vld), .fill_ok(fill_ok), .mem_type(mem_type)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s {vld,fill,type} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] model_kind(input logic [AW-1:0] a, input logic p);
        logic uc = 1'b0;
        logic wc = 1'b0;
        for (int i = 0; i < NR; i++) begin
            if ((a & m_mask[i]) == (m_base[i] & m_mask[i])) begin
                if (m_type[i] == 2'd1) uc = 1'b1;
                if (m_type[i] == 2'd2) wc = 1'b1;
            end
        end
        if (uc) return 2'd1;
        if (wc) return 2'd2;
        return p ? 2'd1 : 2'd0;
    endfunction

    function automatic string pick_tag(input logic [AW-1:0] a, input logic p, input logic pin);
        logic [1:0] k = model_kind(a, 1'b0);
        if (k == 2'd1) return "R4";
        if (k == 2'd2) return "R5";
        if (p) return "R3";
        return pin ? "R8" : "R2";
    endfunction

    task automatic write_range(input int idx, input logic [AW-1:0] b,
                               input logic [AW-1:0] m, input logic [1:0] t);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx[0:0]; cfg_base = b; cfg_mask = m; cfg_type = t;
        m_base[idx] = b; m_mask[idx] = m; m_type[idx] = t;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_access(input logic [AW-1:0] a, input logic p, input logic pin,
                              input logic use_na, input string tag);
        logic [1:0] et = model_kind(a, p);
        logic ef = (et == 2'd0) && !pin;
        @(negedge clk);
        acc_start = 1'b1; acc_addr = a; acc_pcd = p;
        @(negedge clk);
        acc_start = 1'b0;
        if (use_na) next_addr = 1'b1; else burst_rdy = 1'b1;
        cache_en_n = pin;
        @(negedge clk);
        burst_rdy = 1'b0; next_addr = 1'b0;
        check(tag, {decide_vld, fill_ok, mem_type}, {1'b1, ef, et});
    endtask

    task automatic sweep(input string cfg_tag);
        for (int a = 0; a < (1 << AW); a++) begin
            for (int p = 0; p < 2; p++) begin
                for (int pin = 0; pin < 2; pin++) begin
                    string t = (cfg_tag != "") ? cfg_tag : pick_tag(AW'(a), p[0], pin[0]);
                    run_access(AW'(a), p[0], pin[0], a[0], t);
                end
            end
        end
    endtask

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_type[i] = 2'd0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", {decide_vld, fill_ok, mem_type}, 4'b0000);
        // R1: all ranges off after reset, so the page bit and pin alone decide
        sweep("");

        // R4 R5: a write-combining block with an uncacheable sub-block
        write_range(0, 8'h38, 8'hF8, 2'd1);
        write_range(1, 8'h30, 8'hF0, 2'd2);
        sweep("");

        // R6: both ranges cover every address
        write_range(0, 8'h00, 8'h00, 2'd1);
        write_range(1, 8'h00, 8'h00, 2'd2);
        sweep("R6");

        // R7: reserved type on an all-covering range; write-combining on odd addresses
        write_range(0, 8'h00, 8'h00, 2'd3);
        write_range(1, 8'h01, 8'h01, 2'd2);
        sweep("R7");

        // R9: strobes and pin changes after the decision are ignored
        write_range(0, 8'h00, 8'h00, 2'd0);
        write_range(1, 8'h00, 8'h00, 2'd0);
        run_access(8'h22, 1'b0, 1'b0, 1'b0, "R2");
        burst_rdy = 1'b1; cache_en_n = 1'b1;
        @(negedge clk);
        check("R9", {decide_vld, fill_ok, mem_type}, 4'b0100);
        next_addr = 1'b1;
        @(negedge clk);
        burst_rdy = 1'b0; next_addr = 1'b0; cache_en_n = 1'b0;
        check("R9", {decide_vld, fill_ok, mem_type}, 4'b0100);

        // R11: a strobe with no open cycle is ignored
        burst_rdy = 1'b1; cache_en_n = 1'b0;
        @(negedge clk);
        burst_rdy = 1'b0;
        @(negedge clk);
        check("R11", {decide_vld, fill_ok, mem_type}, 4'b0100);

        // R11: a strobe in the start cycle is ignored; the next strobe samples the pin
        acc_start = 1'b1; acc_addr = 8'h44; acc_pcd = 1'b0; burst_rdy = 1'b1; cache_en_n = 1'b1;
        @(negedge clk);
        acc_start = 1'b0; cache_en_n = 1'b0;
        @(negedge clk);
        burst_rdy = 1'b0;
        check("R11", {decide_vld, fill_ok, mem_type}, 4'b1100);

        // R10: a write during an open cycle leaves that cycle's decision alone
        @(negedge clk);
        acc_start = 1'b1; acc_addr = 8'h10; acc_pcd = 1'b0;
        @(negedge clk);
        acc_start = 1'b0;
        cfg_we = 1'b1; cfg_idx = 1'b0; cfg_base = 8'h10; cfg_mask = 8'hFF; cfg_type = 2'd1;
        m_base[0] = 8'h10; m_mask[0] = 8'hFF; m_type[0] = 2'd1;
        @(negedge clk);
        cfg_we = 1'b0; next_addr = 1'b1; cache_en_n = 1'b0;
        @(negedge clk);
        next_addr = 1'b0;
        check("R10", {decide_vld, fill_ok, mem_type}, 4'b1100);
        // R10: the write applies to the next access
        run_access(8'h10, 1'b0, 1'b0, 1'b0, "R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule